// File: doc/BRIEF.md
# SDRAM Refresh and Power-Down Sequencer

This block is the controller-side engine that keeps a two-bank SDRAM refreshed and steers it into and out of its low-power states. It sits beside the access arbiter. It keeps track of which banks are open. When a refresh falls due, it closes any open bank with a precharge-all command and then issues the auto-refresh. After every refresh command it keeps the command bus quiet for a row-cycle window. It also lowers CKE for power-down and for self-refresh. Each power-down is labelled by bank state: active power-down when a bank is still open, precharge power-down when both are closed.

An internal interval counter raises a pending refresh every `REF_INTERVAL` clocks. The sequencer waits for the arbiter's current burst to finish and then takes the bus; new row activations are blocked meanwhile through `block_act`. A self-refresh request first runs a burst of `SR_BURST` auto-refreshes and then issues the self-refresh entry. The device stays in self-refresh for as long as the request is held. When the request drops, CKE is raised with NOPs for a row-cycle window, a second burst of refreshes follows, and only then is the arbiter released.

States: IDLE, PRECH (precharge all), TRP (precharge wait), AREF (auto-refresh), TRC (row-cycle blackout), SRE (self-refresh entry), SELF (in self-refresh), XSR (exit wait), PD (power-down), PDX (power-down exit). Transitions: IDLE→PRECH or IDLE→AREF when a refresh or self-refresh starts with no arbiter burst under way; IDLE→PD on a power-down request; PRECH→TRP; TRP→AREF after the precharge time; AREF→TRC; TRC→AREF while refreshes remain in the burst; TRC→SRE at the end of the entry burst; TRC→IDLE otherwise; SRE→SELF; SELF→XSR when the request drops; XSR→AREF after the exit window, which starts the exit burst; PD→PDX when the request drops or a refresh falls due; PDX→IDLE.

Top module: `sdram_rfpd_seq`

## Requirements
- R1: After reset, cke is 1, the command bus shows NOP, and busy and block_act are 0.
- R2: A refresh falls due `REF_INTERVAL` clocks after reset or after the last refresh command, and block_act goes high. No command is issued while burst_busy is high.
- R3: When any bank is open, a refresh starts with a precharge-all (a10=1), and the refresh command follows exactly T_RP cycles later. Once a refresh has run, both banks count as closed, so a later refresh is issued with no precharge.
- R4: After each auto-refresh, only NOPs appear for the next T_RC-1 cycles, so the next command comes no earlier than T_RC cycles after it.
- R5: busy is high from the precharge cycle, or from the refresh cycle when no precharge is needed, until the last blackout cycle. It is low in the cycle after the blackout.
- R6: In power-down, cke is 0 and no command is issued. pd_active is 1 when a bank is open, and pd_precharge is 1 when both banks are closed.
- R7: Power-down ends with one cke-high NOP cycle, either when pd_req drops or when a refresh falls due. A refresh that falls due is issued two cycles after cke rises.
- R8: A self-refresh request issues SR_BURST auto-refreshes spaced T_RC apart. T_RC cycles after the last of them comes the self-refresh entry, which is the refresh code with cke=0.
- R9: While sr_req stays high after entry, cke stays 0 and the bus shows NOP.
- R10: When sr_req drops, cke rises with NOPs. Exactly T_RC cycles later the first of SR_BURST refreshes follows, and busy stays high until the blackout after the last one.
- R11: Command codes on {cs_n,ras_n,cas_n,we_n} are NOP=0111, precharge=0010 and refresh=0001.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| act_evt | input | NUM_BANKS | Arbiter opened a row in bank i this cycle |
| pre_evt | input | NUM_BANKS | Arbiter closed bank i this cycle |
| burst_busy | input | 1 | Arbiter burst in progress |
| sr_req | input | 1 | Level request to enter and stay in self-refresh |
| pd_req | input | 1 | Level request for power-down |
| cke | output | 1 | Clock enable to the SDRAM |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| a10 | output | 1 | Address bit 10; high selects all banks for precharge |
| busy | output | 1 | Sequencer owns the command bus |
| block_act | output | 1 | Arbiter must not open new rows |
| pd_active | output | 1 | In power-down with a bank open |
| pd_precharge | output | 1 | In power-down with all banks closed |

## Verification
If the bank tracker holds a wrong value, the error shows at the ports on the next refresh. A stale open flag produces an extra precharge, and a lost open flag produces a refresh with no precharge before it. In power-down the same error shows at once on the pd_active/pd_precharge pair. A fault in the wait counter or the burst counter moves the gap between consecutive commands, or changes how many refreshes bracket self-refresh, so it shows within one T_RC window. The scoreboard compares every non-NOP command's code, cke, a10 and its spacing from the previous event, which catches all of these within a few cycles.

// File: rtl/rfpd_pkg.sv
package rfpd_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PRECH,
        ST_TRP,
        ST_AREF,
        ST_TRC,
        ST_SRE,
        ST_SELF,
        ST_XSR,
        ST_PD,
        ST_PDX
    } seq_state_t;

    typedef enum logic [1:0] {
        PH_ONE,
        PH_PRE_SR,
        PH_POST_SR
    } seq_phase_t;

    // {cs_n, ras_n, cas_n, we_n}
    typedef logic [3:0] bus_cmd_t;
    localparam bus_cmd_t CMD_NOP = 4'b0111;
    localparam bus_cmd_t CMD_PRE = 4'b0010;
    localparam bus_cmd_t CMD_REF = 4'b0001;

endpackage

// File: rtl/rfpd_interval.sv
module rfpd_interval #(
    parameter int LIMIT = 1560
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic pending
);
    localparam int IW = $clog2(LIMIT + 1);

    logic [IW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            cnt     <= '0;
            pending <= 1'b0;
        end else if (cnt == IW'(LIMIT - 1)) begin
            pending <= 1'b1;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/rfpd_bank_track.sv
module rfpd_bank_track #(
    parameter int NB = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NB-1:0] act_evt,
    input  logic [NB-1:0] pre_evt,
    input  logic          pre_all,
    output logic [NB-1:0] open_q
);
    for (genvar b = 0; b < NB; b++) begin : g_bank
        always_ff @(posedge clk) begin
            if (!rst_n || pre_all || pre_evt[b])
                open_q[b] <= 1'b0;
            else if (act_evt[b])
                open_q[b] <= 1'b1;
        end
    end
endmodule

// File: rtl/rfpd_wait.sv
module rfpd_wait #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] val,
    output logic         last
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign last = (cnt == W'(1));
endmodule

// File: rtl/sdram_rfpd_seq.sv
module sdram_rfpd_seq
    import rfpd_pkg::*;
#(
    parameter int NUM_BANKS    = 2,
    parameter int T_RP         = 3,
    parameter int T_RC         = 9,
    parameter int REF_INTERVAL = 1560,
    parameter int SR_BURST     = 4096
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_BANKS-1:0] act_evt,
    input  logic [NUM_BANKS-1:0] pre_evt,
    input  logic                 burst_busy,
    input  logic                 sr_req,
    input  logic                 pd_req,
    output logic                 cke,
    output logic                 cs_n,
    output logic                 ras_n,
    output logic                 cas_n,
    output logic                 we_n,
    output logic                 a10,
    output logic                 busy,
    output logic                 block_act,
    output logic                 pd_active,
    output logic                 pd_precharge
);
    localparam int TW = $clog2(T_RC + T_RP + 1);
    localparam int BW = $clog2(SR_BURST + 1);

    seq_state_t st, st_nxt;
    seq_phase_t ph, ph_nxt;
    logic [BW-1:0] brst;
    logic [BW-1:0] brst_val;
    logic          brst_load;
    logic          wt_load;
    logic [TW-1:0] wt_val;
    logic          wt_last;
    logic          ref_pend;
    logic [NUM_BANKS-1:0] bank_open;
    logic          any_open;
    bus_cmd_t      cmd;

    assign any_open = |bank_open;

    rfpd_interval #(.LIMIT(REF_INTERVAL)) u_interval (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (st == ST_AREF || st == ST_SRE),
        .pending (ref_pend)
    );

    rfpd_bank_track #(.NB(NUM_BANKS)) u_banks (
        .clk     (clk),
        .rst_n   (rst_n),
        .act_evt (act_evt),
        .pre_evt (pre_evt),
        .pre_all (st == ST_PRECH),
        .open_q  (bank_open)
    );

    rfpd_wait #(.W(TW)) u_wait (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (wt_load),
        .val   (wt_val),
        .last  (wt_last)
    );

    // state, phase and burst registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st   <= ST_IDLE;
            ph   <= PH_ONE;
            brst <= '0;
        end else begin
            st <= st_nxt;
            ph <= ph_nxt;
            if (brst_load)
                brst <= brst_val;
            else if (st == ST_AREF)
                brst <= brst - 1'b1;
        end
    end

    // next-state logic
    always_comb begin
        st_nxt    = st;
        ph_nxt    = ph;
        brst_load = 1'b0;
        brst_val  = '0;
        wt_load   = 1'b0;
        wt_val    = '0;
        unique case (st)
            ST_IDLE: begin
                if (!burst_busy && (sr_req || ref_pend)) begin
                    brst_load = 1'b1;
                    brst_val  = sr_req ? BW'(SR_BURST) : BW'(1);
                    ph_nxt    = sr_req ? PH_PRE_SR : PH_ONE;
                    st_nxt    = any_open ? ST_PRECH : ST_AREF;
                end else if (!burst_busy && pd_req) begin
                    st_nxt = ST_PD;
                end
            end
            ST_PRECH: begin
                wt_load = 1'b1;
                wt_val  = TW'(T_RP - 1);
                st_nxt  = ST_TRP;
            end
            ST_TRP:
                if (wt_last) st_nxt = ST_AREF;
            ST_AREF: begin
                wt_load = 1'b1;
                wt_val  = TW'(T_RC - 1);
                st_nxt  = ST_TRC;
            end
            ST_TRC: begin
                if (wt_last) begin
                    if (brst != '0)         st_nxt = ST_AREF;
                    else if (ph == PH_PRE_SR) st_nxt = ST_SRE;
                    else                    st_nxt = ST_IDLE;
                end
            end
            ST_SRE:
                st_nxt = ST_SELF;
            ST_SELF: begin
                if (!sr_req) begin
                    wt_load = 1'b1;
                    wt_val  = TW'(T_RC);
                    st_nxt  = ST_XSR;
                end
            end
            ST_XSR: begin
                if (wt_last) begin
                    brst_load = 1'b1;
                    brst_val  = BW'(SR_BURST);
                    ph_nxt    = PH_POST_SR;
                    st_nxt    = ST_AREF;
                end
            end
            ST_PD:
                if (!pd_req || ref_pend) st_nxt = ST_PDX;
            ST_PDX:
                st_nxt = ST_IDLE;
            default:
                st_nxt = ST_IDLE;
        endcase
    end

    // outputs decoded from state
    always_comb begin
        cke  = 1'b1;
        cmd  = CMD_NOP;
        a10  = 1'b0;
        busy = 1'b0;
        unique case (st)
            ST_PRECH: begin cmd = CMD_PRE; a10 = 1'b1; busy = 1'b1; end
            ST_TRP:   busy = 1'b1;
            ST_AREF:  begin cmd = CMD_REF; busy = 1'b1; end
            ST_TRC:   busy = 1'b1;
            ST_SRE:   begin cmd = CMD_REF; cke = 1'b0; busy = 1'b1; end
            ST_SELF:  begin cke = 1'b0; busy = 1'b1; end
            ST_XSR:   busy = 1'b1;
            ST_PD:    cke = 1'b0;
            default:  ;
        endcase
    end

    assign {cs_n, ras_n, cas_n, we_n} = cmd;
    assign block_act    = ref_pend || (st != ST_IDLE);
    assign pd_active    = (st == ST_PD) && any_open;
    assign pd_precharge = (st == ST_PD) && !any_open;

endmodule

// File: rtl/rfpd_seq_chk.sv
module rfpd_seq_chk #(
    parameter int NUM_BANKS = 2,
    parameter int T_RC      = 9
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 cke,
    input logic                 cs_n,
    input logic                 ras_n,
    input logic                 cas_n,
    input logic                 we_n,
    input logic                 a10,
    input logic                 busy,
    input logic                 pd_active,
    input logic                 pd_precharge,
    input logic [NUM_BANKS-1:0] bank_open
);
    localparam int QW = $clog2(T_RC + 1);

    logic [3:0]    code;
    logic          is_nop;
    logic          is_pre;
    logic          is_aref;
    logic [QW-1:0] quiet;

    assign code    = {cs_n, ras_n, cas_n, we_n};
    assign is_nop  = (code == 4'b0111);
    assign is_pre  = (code == 4'b0010);
    assign is_aref = (code == 4'b0001) && cke;

    always_ff @(posedge clk) begin
        if (!rst_n)
            quiet <= '0;
        else if (is_aref)
            quiet <= QW'(T_RC - 1);
        else if (quiet != '0)
            quiet <= quiet - 1'b1;
    end

    AST_REF_BANKS_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
        (code == 4'b0001) |-> (bank_open == '0)); // R3
    AST_PRE_ALL_BANKS: assert property (@(posedge clk) disable iff (!rst_n)
        is_pre |-> a10); // R11
    AST_TRC_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (quiet != '0) |-> is_nop); // R4
    AST_BUSY_AFTER_PRE: assert property (@(posedge clk) disable iff (!rst_n)
        is_pre |=> busy); // R5
    AST_PD_CKE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (pd_active || pd_precharge) |-> (!cke && is_nop)); // R6
    AST_LOWPOWER_NOP: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke && $past(!cke)) |-> is_nop); // R9
    AST_CKE_RISE_NOP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cke) |-> is_nop); // R10
    AST_SRE_AFTER_BLACKOUT: assert property (@(posedge clk) disable iff (!rst_n)
        ((code == 4'b0001) && !cke) |-> $past(busy)); // R8
endmodule

bind sdram_rfpd_seq rfpd_seq_chk #(
    .NUM_BANKS (NUM_BANKS),
    .T_RC      (T_RC)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cke          (cke),
    .cs_n         (cs_n),
    .ras_n        (ras_n),
    .cas_n        (cas_n),
    .we_n         (we_n),
    .a10          (a10),
    .busy         (busy),
    .pd_active    (pd_active),
    .pd_precharge (pd_precharge),
    .bank_open    (bank_open)
);

// File: tb/tb_sdram_rfpd_seq.sv
module tb_sdram_rfpd_seq;

    localparam int NB    = 2;
    localparam int TRP   = 2;
    localparam int TRC   = 4;
    localparam int RINT  = 100;
    localparam int BURST = 3;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [NB-1:0] act_evt;
    logic [NB-1:0] pre_evt;
    logic          burst_busy;
    logic          sr_req;
    logic          pd_req;
    logic cke, cs_n, ras_n, cas_n, we_n, a10;
    logic busy, block_act, pd_active, pd_precharge;

    always #4 clk = ~clk;

    sdram_rfpd_seq #(
        .NUM_BANKS(NB), .T_RP(TRP), .T_RC(TRC),
        .REF_INTERVAL(RINT), .SR_BURST(BURST)
    ) dut (
        .clk(clk), .rst_n(rst_n), .act_evt(act_evt), .pre_evt(pre_evt),
        .burst_busy(burst_busy), .sr_req(sr_req), .pd_req(pd_req),
        .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .a10(a10), .busy(busy), .block_act(block_act),
        .pd_active(pd_active), .pd_precharge(pd_precharge)
    );

    typedef struct {
        logic [3:0] code;
        logic       ck;
        logic       ad;
        int         gap;
        string      req;
    } exp_t;

    exp_t exp_q[$];
    int checks   = 0;
    int failures = 0;
    int cyc      = 0;
    int last_cyc = 0;
    int n_seen   = 0;
    bit done     = 0;
    logic prev_cke = 1'b1;

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic push(input logic [3:0] code, input logic ck, input logic ad,
                        input int gap, input string req);
        exp_t e;
        e.code = code; e.ck = ck; e.ad = ad; e.gap = gap; e.req = req;
        exp_q.push_back(e);
    endtask

    // monitor: compare every non-NOP command against the scoreboard
    initial begin
        forever begin
            @(negedge clk);
            cyc++;
            if (rst_n) begin
                if (cke && !prev_cke) last_cyc = cyc;
                if ({cs_n, ras_n, cas_n, we_n} != 4'b0111) begin
                    if (exp_q.size() == 0) begin
                        chk(0, "R2 unexpected command", int'({cs_n, ras_n, cas_n, we_n}), 7);
                    end else begin
                        exp_t e;
                        e = exp_q.pop_front();
                        chk({cs_n, ras_n, cas_n, we_n} == e.code, {e.req, " code"},
                            int'({cs_n, ras_n, cas_n, we_n}), int'(e.code));
                        chk(cke == e.ck, {e.req, " cke"}, int'(cke), int'(e.ck));
                        chk(a10 == e.ad, {e.req, " a10"}, int'(a10), int'(e.ad));
                        if (e.gap >= 0)
                            chk(cyc - last_cyc == e.gap, {e.req, " gap"}, cyc - last_cyc, e.gap);
                    end
                    last_cyc = cyc;
                    n_seen++;
                end
                prev_cke = cke;
            end
        end
    end

    task automatic wait_seen(input int n);
        int t;
        t = 0;
        while (n_seen < n && t < 2000) begin
            @(negedge clk);
            t++;
        end
        chk(n_seen >= n, "R8 command count", n_seen, n);
    endtask

    // after the last refresh: busy for TRC-1 cycles, then low
    task automatic check_blackout(input string req);
        for (int k = 1; k < TRC; k++) begin
            @(negedge clk);
            chk(busy == 1'b1, req, int'(busy), 1);
        end
        @(negedge clk);
        chk(busy == 1'b0, req, int'(busy), 0);
    endtask

    initial begin
        #(8 * 100000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int t;
        rst_n = 1'b0; act_evt = '0; pre_evt = '0;
        burst_busy = 1'b0; sr_req = 1'b0; pd_req = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(cke == 1'b1, "R1 cke", int'(cke), 1);
        chk({cs_n, ras_n, cas_n, we_n} == 4'b0111, "R1 nop",
            int'({cs_n, ras_n, cas_n, we_n}), 7);
        chk(busy == 1'b0, "R1 busy", int'(busy), 0);
        chk(block_act == 1'b0, "R1 block_act", int'(block_act), 0);

        // open bank 0, hold the arbiter busy across the refresh due point
        act_evt = 2'b01; @(negedge clk); act_evt = '0;
        burst_busy = 1'b1;
        repeat (40) @(negedge clk);
        chk(block_act == 1'b0, "R2 not yet due", int'(block_act), 0);
        t = 0;
        while (!block_act && t < 200) begin @(negedge clk); t++; end
        chk(block_act == 1'b1, "R2 due", int'(block_act), 1);
        repeat (6) @(negedge clk);
        chk(busy == 1'b0, "R2 held by burst", int'(busy), 0);
        push(4'b0010, 1'b1, 1'b1, -1, "R3 precharge");
        push(4'b0001, 1'b1, 1'b0, TRP, "R3 refresh after tRP");
        burst_busy = 1'b0;
        wait_seen(2);
        check_blackout("R4 R5 blackout busy");

        // power-down with bank 1 open, then with all closed
        act_evt = 2'b10; @(negedge clk); act_evt = '0;
        pd_req = 1'b1;
        repeat (3) @(negedge clk);
        chk(cke == 1'b0, "R6 cke low", int'(cke), 0);
        chk(pd_active == 1'b1, "R6 active class", int'(pd_active), 1);
        chk(pd_precharge == 1'b0, "R6 not precharge class", int'(pd_precharge), 0);
        pd_req = 1'b0;
        @(negedge clk);
        chk(cke == 1'b1, "R7 exit on drop", int'(cke), 1);
        pre_evt = 2'b10; @(negedge clk); pre_evt = '0;
        push(4'b0001, 1'b1, 1'b0, 2, "R7 R3 refresh from power-down");
        pd_req = 1'b1;
        repeat (3) @(negedge clk);
        chk(pd_precharge == 1'b1, "R6 precharge class", int'(pd_precharge), 1);
        chk(pd_active == 1'b0, "R6 not active class", int'(pd_active), 0);
        wait_seen(3);
        pd_req = 1'b0;
        t = 0;
        while ((busy || !cke) && t < 50) begin @(negedge clk); t++; end

        // self-refresh with bank 0 open
        act_evt = 2'b01; @(negedge clk); act_evt = '0;
        push(4'b0010, 1'b1, 1'b1, -1, "R8 precharge");
        push(4'b0001, 1'b1, 1'b0, TRP, "R8 refresh 1");
        for (int k = 2; k <= BURST; k++)
            push(4'b0001, 1'b1, 1'b0, TRC, "R8 burst refresh");
        push(4'b0001, 1'b0, 1'b0, TRC, "R8 entry");
        sr_req = 1'b1;
        wait_seen(3 + 2 + BURST);
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            chk(cke == 1'b0, "R9 cke held low", int'(cke), 0);
        end
        for (int k = 1; k <= BURST; k++)
            push(4'b0001, 1'b1, 1'b0, TRC, "R10 exit burst");
        sr_req = 1'b0;
        @(negedge clk);
        chk(cke == 1'b1, "R10 cke raised", int'(cke), 1);
        chk(busy == 1'b1, "R10 busy in exit", int'(busy), 1);
        wait_seen(5 + 2 * BURST);
        check_blackout("R10 busy until burst done");
        repeat (5) @(negedge clk);
        chk(exp_q.size() == 0, "R11 all commands seen", exp_q.size(), 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule